// File: doc/BRIEF.md
# Serial Readout Token Arbiter

This block decides, for one slice in a chain of parallel-in, serial-out FIFO slices, when that slice may drive a serial data line that all slices share. The slices run from one shift clock and see the same shift enable. Each slice has an expansion input and an expansion output, and each output is wired to the next slice's input; for depth cascading the last output closes back onto the first input as a ring. A single token moves around that ring as a one-period pulse. Only the slice holding the token enables its line driver and shifts.

The first holder is fixed by an active-low first-load input, which is looked at only while reset is active. A slice whose expansion input is high during reset treats itself as a standalone device. It then keeps permanent ownership, and its expansion pin carries the almost-empty/almost-full status instead of token pulses. When a holding slice shifts out the final bit of a word, it gives up the token and raises its expansion output for exactly one shift-enable period. A holding slice whose local store is empty keeps the token and waits, so that words leave the chain in the order they were written.

Top module: `serial_token_arb`

## Requirements
- R1: While `rstN` is low with `expIn` low, the slice latches `firstLoadN`. A low value makes it the token holder, with `driveEn`=1 once reset ends. A high value makes it a non-holder, with `driveEn`=0.
- R2: If `expIn` is high while `rstN` is low, the slice enters standalone mode. In that mode `driveEn` stays 1, `expOut` equals `almostFlagN` in the same cycle, and `wordDone` has no effect on ownership.
- R3: A non-holder in expansion mode becomes the holder at a clock edge where `shiftEn` and `expIn` are both 1, and `driveEn` is 1 from the next cycle. `expIn` high without `shiftEn` has no effect.
- R4: A holder that sees `shiftEn`=1, `localEmpty`=0 and `wordDone`=1 at an edge drops ownership at that edge. From the next cycle `driveEn`=0 and `expOut`=1.
- R5: Once raised, `expOut` stays 1 through every edge with `shiftEn`=0 and returns to 0 at the first edge with `shiftEn`=1. The pulse therefore lasts exactly one shift-enable period.
- R6: A holder with `localEmpty`=1 keeps the token whatever `wordDone` and `shiftEn` are, and emits no pulse.
- R7: `shiftOk` is 1 exactly when `shiftEn` is 1, the slice holds the token or is standalone, and `localEmpty` is 0. A non-holder never shifts.
- R8: After reset ends, changes on `firstLoadN` have no effect on ownership.
- R9: In expansion mode `almostFlagN` is ignored, and `expOut` is 0 whenever no pulse is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared shift clock |
| rstN | input | 1 | Synchronous active-low reset; first-load and mode are sampled while low |
| firstLoadN | input | 1 | Low during reset marks this slice as the first holder |
| expIn | input | 1 | Expansion input; token pulse from previous slice, or held high for standalone mode |
| shiftEn | input | 1 | Shift enable common to all slices |
| localEmpty | input | 1 | Local FIFO store holds no word |
| wordDone | input | 1 | Current shift moves out the last bit of the word |
| almostFlagN | input | 1 | Almost-empty/almost-full status from the local flag logic |
| driveEn | output | 1 | Enable for this slice's driver on the shared serial line |
| shiftOk | output | 1 | Local shift permitted this cycle |
| expOut | output | 1 | Expansion output: token pulse, or almost flag in standalone mode |

## Verification
The checker verifies, on every cycle, that ownership is handed off when a word ends, that the pulse lasts one shift-enable period, that an empty holder keeps the token, that a token is taken only on a qualified expansion pulse, and that standalone mode never changes. Several behaviours can only be shown by the bench's scenarios: the value latched from `firstLoadN` during reset, the effect of `expIn` during reset on the mode, the pass-through of the almost flag, and the fact that `firstLoadN` and `almostFlagN` are ignored at other times. The bench resets into each starting state and sweeps every combination of shift enable, empty status and word completion. It computes the expected ownership and pulse arithmetically from those inputs.

// File: rtl/tokchain_pkg.sv
package tokchain_pkg;

  typedef enum logic [1:0] {
    TK_WAIT = 2'd0,
    TK_HOLD = 2'd1,
    TK_SOLO = 2'd2
  } tokState_t;

  typedef struct packed {
    logic dropTok;
    logic shiftTick;
  } tokStrobe_t;

endpackage

// File: rtl/token_ctrl.sv
module token_ctrl
  import tokchain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       firstLoadN,
  input  logic       expIn,
  input  logic       shiftEn,
  input  logic       localEmpty,
  input  logic       wordDone,
  output tokStrobe_t strobe,
  output logic       ownTok,
  output logic       soloMode
);

  tokState_t state;
  tokState_t stateNext;
  logic      wordLeaves;

  always_comb wordLeaves = shiftEn && !localEmpty && wordDone;

  always_comb begin
    stateNext = state;
    unique case (state)
      TK_WAIT: if (shiftEn && expIn) stateNext = TK_HOLD;
      TK_HOLD: if (wordLeaves)       stateNext = TK_WAIT;
      default: stateNext = state;
    endcase
  end

  // Mode and first holder are taken from the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (expIn)           state <= TK_SOLO;
      else if (firstLoadN) state <= TK_WAIT;
      else                 state <= TK_HOLD;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    ownTok           = (state == TK_HOLD);
    soloMode         = (state == TK_SOLO);
    strobe.dropTok   = (state == TK_HOLD) && wordLeaves;
    strobe.shiftTick = shiftEn;
  end

endmodule

// File: rtl/token_path.sv
module token_path
  import tokchain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tokStrobe_t strobe,
  input  logic       ownTok,
  input  logic       soloMode,
  input  logic       localEmpty,
  input  logic       almostFlagN,
  output logic       driveEn,
  output logic       shiftOk,
  output logic       expOut
);

  logic pulseQ;
  logic mayShift;

  // Pulse rises with the hand-off and lasts until the next shift enable.
  always_ff @(posedge clk) begin
    if (!rstN)                 pulseQ <= 1'b0;
    else if (strobe.dropTok)   pulseQ <= 1'b1;
    else if (strobe.shiftTick) pulseQ <= 1'b0;
  end

  always_comb begin
    mayShift = ownTok || soloMode;
    driveEn  = mayShift;
    shiftOk  = strobe.shiftTick && mayShift && !localEmpty;
    expOut   = soloMode ? almostFlagN : pulseQ;
  end

endmodule

// File: rtl/serial_token_arb.sv
module serial_token_arb
  import tokchain_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic firstLoadN,
  input  logic expIn,
  input  logic shiftEn,
  input  logic localEmpty,
  input  logic wordDone,
  input  logic almostFlagN,
  output logic driveEn,
  output logic shiftOk,
  output logic expOut
);

  tokStrobe_t strobe;
  logic       ownTok;
  logic       soloMode;

  token_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .firstLoadN (firstLoadN),
    .expIn      (expIn),
    .shiftEn    (shiftEn),
    .localEmpty (localEmpty),
    .wordDone   (wordDone),
    .strobe     (strobe),
    .ownTok     (ownTok),
    .soloMode   (soloMode)
  );

  token_path i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ownTok      (ownTok),
    .soloMode    (soloMode),
    .localEmpty  (localEmpty),
    .almostFlagN (almostFlagN),
    .driveEn     (driveEn),
    .shiftOk     (shiftOk),
    .expOut      (expOut)
  );

endmodule

// File: rtl/token_arb_chk.sv
module token_arb_chk (
  input logic clk,
  input logic rstN,
  input logic expIn,
  input logic shiftEn,
  input logic localEmpty,
  input logic wordDone,
  input logic driveEn,
  input logic expOut,
  input logic soloMode
);

  AST_HANDOFF_ON_WORD_END: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && driveEn && shiftEn && !localEmpty && wordDone) |=> (!driveEn && expOut)); // R4

  AST_PULSE_ENDS_ON_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && expOut && shiftEn) |=> !expOut); // R5

  AST_PULSE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && expOut && !shiftEn) |=> expOut); // R5

  AST_EMPTY_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && driveEn && localEmpty) |=> (driveEn && !$rose(expOut))); // R6

  AST_TAKE_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && !driveEn && shiftEn && expIn) |=> driveEn); // R3

  AST_NO_TAKE_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!soloMode && !driveEn && !(shiftEn && expIn)) |=> !driveEn); // R3

  AST_SOLO_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    soloMode |-> driveEn); // R2

  AST_SOLO_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    soloMode |=> soloMode); // R2

endmodule

bind serial_token_arb token_arb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .expIn      (expIn),
  .shiftEn    (shiftEn),
  .localEmpty (localEmpty),
  .wordDone   (wordDone),
  .driveEn    (driveEn),
  .expOut     (expOut),
  .soloMode   (soloMode)
);

// File: tb/test_serial_token_arb.sv
module test_serial_token_arb;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, firstLoadN, expIn, shiftEn, localEmpty, wordDone, almostFlagN;
  logic driveEn, shiftOk, expOut;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  serial_token_arb i_serial_token_arb (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN), .expIn(expIn),
    .shiftEn(shiftEn), .localEmpty(localEmpty), .wordDone(wordDone),
    .almostFlagN(almostFlagN), .driveEn(driveEn), .shiftOk(shiftOk),
    .expOut(expOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic fl, input logic solo);
    rstN = 1'b0; firstLoadN = fl; expIn = solo;
    shiftEn = 1'b0; localEmpty = 1'b0; wordDone = 1'b0; almostFlagN = 1'b1;
    tick(); tick();
    rstN = 1'b1;
    expIn = solo;
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 first holder / non-holder from reset
    doReset(1'b0, 1'b0);
    chk(driveEn, 1'b1, "R1 first-load low holds token");
    chk(expOut, 1'b0, "R1 no pulse after reset");
    doReset(1'b1, 1'b0);
    chk(driveEn, 1'b0, "R1 first-load high waits");

    // R8 first-load ignored after reset
    firstLoadN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(driveEn, 1'b0, "R8 first-load after reset ignored");
    end

    // Holder sweep: R4 R5 R6 R7 R9
    for (int c = 0; c < 8; c++) begin
      logic se, em, wd, rel;
      se = c[0]; em = c[1]; wd = c[2];
      rel = se & ~em & wd;
      doReset(1'b0, 1'b0);
      almostFlagN = 1'b0;
      shiftEn = se; localEmpty = em; wordDone = wd;
      #1;
      chk(shiftOk, se & ~em, "R7 holder shift permission");
      chk(expOut, 1'b0, "R9 almost flag ignored in expansion");
      tick();
      chk(driveEn, ~rel, "R4/R6 ownership after word end");
      chk(expOut, rel, "R4 pulse on hand-off");
      if (rel) begin
        shiftEn = 1'b0; wordDone = 1'b0;
        for (int g = 0; g < c % 3 + 1; g++) begin
          tick();
          chk(expOut, 1'b1, "R5 pulse held without shift enable");
        end
        #1;
        chk(shiftOk, 1'b0, "R7 non-holder no shift");
        shiftEn = 1'b1;
        #1;
        chk(shiftOk, 1'b0, "R7 non-holder no shift with enable");
        tick();
        chk(expOut, 1'b0, "R5 pulse ends on shift enable");
        chk(driveEn, 1'b0, "R4 stays released");
      end
    end

    // Non-holder sweep: R3
    for (int c = 0; c < 4; c++) begin
      logic se, ei;
      se = c[0]; ei = c[1];
      doReset(1'b1, 1'b0);
      shiftEn = se; expIn = ei;
      tick();
      chk(driveEn, se & ei, "R3 take token on qualified pulse");
      expIn = 1'b0; shiftEn = 1'b0;
    end

    // Empty holder keeps token, then releases when data arrives: R6
    doReset(1'b0, 1'b0);
    shiftEn = 1'b1; localEmpty = 1'b1; wordDone = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(driveEn, 1'b1, "R6 empty holder keeps token");
      chk(expOut, 1'b0, "R6 empty holder no pulse");
    end
    localEmpty = 1'b0;
    tick();
    chk(driveEn, 1'b0, "R6 release after data arrives");
    chk(expOut, 1'b1, "R4 pulse after data arrives");
    // ring of one: pulse fed back as expIn
    expIn = expOut; wordDone = 1'b0;
    tick();
    chk(driveEn, 1'b1, "R3 token returns around ring");
    chk(expOut, 1'b0, "R5 pulse ended in ring");
    expIn = 1'b0;

    // Standalone mode: R2
    doReset(1'b1, 1'b1);
    chk(driveEn, 1'b1, "R2 standalone drives");
    for (int c = 0; c < 16; c++) begin
      almostFlagN = c[0]; shiftEn = c[1]; localEmpty = c[2]; wordDone = c[3];
      #1;
      chk(expOut, c[0], "R2 almost flag passes through");
      chk(shiftOk, c[1] & ~c[2], "R7 standalone shift permission");
      tick();
      chk(driveEn, 1'b1, "R2 word end keeps standalone ownership");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule